// File: doc/BRIEF.md
# Data Address Compare Watchpoint Unit

A debug watchpoint unit that watches every data load and store and compares its address against two programmed compare values. It raises read or write watchpoint events for either comparator. A shared two-bit mode field gives four ways of using the pair:

- exact equality, with each comparator checked on its own;
- a masked bit match, where the second value is the mask;
- an inclusive address window;
- an exclusive address window.

Each comparator applies its own privilege qualifier, address-space qualifier and per-direction enables before it records an event.

Events land in four sticky status bits. Software clears them by writing ones to a clear mask. Detection runs at all times and has no debug-enable gating. Exception delivery to the core is left to the surrounding logic.

Top module: `dac_watch_unit`

## Requirements
- R1: While `rst_n` is low, `wp_status` is 0. Bit 0 is comparator 1 read, bit 1 is comparator 1 write, bit 2 is comparator 2 read and bit 3 is comparator 2 write.
- R2: With `cfg_mode` = 2'b00 (exact), comparator 1 hits when `acc_addr` == `cmp1_val`, and comparator 2 hits when `acc_addr` == `cmp2_val`. Each comparator is checked independently of the other.
- R3: With `cfg_mode` = 2'b01 (masked), both comparators hit when (`acc_addr` & `cmp2_val`) == (`cmp1_val` & `cmp2_val`).
- R4: With `cfg_mode` = 2'b10 (inside), both comparators hit when `cmp1_val` <= `acc_addr` < `cmp2_val`. The comparison is unsigned.
- R5: With `cfg_mode` = 2'b11 (outside), both comparators hit when `acc_addr` < `cmp1_val` or `acc_addr` >= `cmp2_val`. The comparison is unsigned.
- R6: In the masked, inside and outside modes, one hit condition serves both comparators. Each comparator still records the event only if its own enables and qualifiers pass.
- R7: Privilege qualifier `cfg_privN`: 2'b0x allows any level, 2'b10 allows only `acc_user` = 1, and 2'b11 allows only `acc_user` = 0.
- R8: Address-space qualifier `cfg_spaceN`: 2'b0x ignores `acc_space`, 2'b10 requires `acc_space` = 0, and 2'b11 requires `acc_space` = 1.
- R9: A qualified hit with `acc_is_write` = 0 sets the comparator's read bit, but only when its `cfg_rdenN` is 1. A qualified hit with `acc_is_write` = 1 sets the write bit, but only when its `cfg_wrenN` is 1. A hit never sets a bit of the other direction.
- R10: Status bits are sticky. A cycle with `clr_strobe` = 1 clears exactly the bits set in `clr_mask` and leaves all other bits unchanged.
- R11: An event that sets a bit in the same cycle as a clear of that bit leaves the bit set.
- R12: An access is sampled at the rising edge where `acc_valid` = 1, and its event shows on `wp_status` after that edge. A cycle with `acc_valid` = 0 sets no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Data access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_is_write | input | 1 | 1 = store, 0 = load |
| acc_user | input | 1 | 1 = user level, 0 = supervisor |
| acc_space | input | 1 | Address-space bit of the access |
| cfg_mode | input | 2 | Shared compare mode |
| cmp1_val | input | ADDR_W | Compare value 1 |
| cmp2_val | input | ADDR_W | Compare value 2 |
| cfg_priv1 | input | 2 | Privilege qualifier, comparator 1 |
| cfg_priv2 | input | 2 | Privilege qualifier, comparator 2 |
| cfg_space1 | input | 2 | Address-space qualifier, comparator 1 |
| cfg_space2 | input | 2 | Address-space qualifier, comparator 2 |
| cfg_rden1 | input | 1 | Read event enable, comparator 1 |
| cfg_wren1 | input | 1 | Write event enable, comparator 1 |
| cfg_rden2 | input | 1 | Read event enable, comparator 2 |
| cfg_wren2 | input | 1 | Write event enable, comparator 2 |
| clr_strobe | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 4 | Bits to clear when strobed |
| wp_status | output | 4 | Sticky event status |

## Verification
The bench builds the unit with `ADDR_W` = 8. At that width every address can be swept in each of the four modes, with compare values chosen so that both window edges and partial masks are hit. The same small width keeps an exhaustive walk over qualifier, privilege, address-space, direction and enable combinations short. This exposes every edge of the unsigned comparisons and the way a shared hit fans out to both comparators.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

   localparam int NUM_CMP = 2;
   localparam int EVT_W   = 2 * NUM_CMP;

   typedef enum logic [1:0] {
      MODE_EXACT   = 2'b00,
      MODE_MASKED  = 2'b01,
      MODE_INSIDE  = 2'b10,
      MODE_OUTSIDE = 2'b11
   } dacw_mode_e;

endpackage

// File: rtl/dacw_match.sv
module dacw_match
   import dacw_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [ADDR_W-1:0]  val1,
   input  logic [ADDR_W-1:0]  val2,
   input  logic [1:0]         mode,
   output logic [NUM_CMP-1:0] hit
);

   logic [ADDR_W-1:0]  vals [NUM_CMP];
   logic [NUM_CMP-1:0] equal;
   logic               ge_lo, lt_hi, masked_eq, shared_hit;

   assign vals[0] = val1;
   assign vals[1] = val2;

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_eq
      assign equal[i] = (addr == vals[i]);
   end

   assign ge_lo     = (addr >= val1);
   assign lt_hi     = (addr <  val2);
   assign masked_eq = ((addr & val2) == (val1 & val2));

   always_comb begin
      unique case (dacw_mode_e'(mode))
         MODE_MASKED:  shared_hit = masked_eq;
         MODE_INSIDE:  shared_hit = ge_lo & lt_hi;
         MODE_OUTSIDE: shared_hit = ~ge_lo | ~lt_hi;
         default:      shared_hit = 1'b0;
      endcase
   end

   assign hit = (dacw_mode_e'(mode) == MODE_EXACT) ? equal : {NUM_CMP{shared_hit}};

endmodule

// File: rtl/dacw_qual.sv
module dacw_qual (
   input  logic [1:0] priv_cfg,
   input  logic [1:0] space_cfg,
   input  logic       rd_en,
   input  logic       wr_en,
   input  logic       is_user,
   input  logic       space_bit,
   input  logic       is_write,
   output logic       rd_ok,
   output logic       wr_ok
);

   logic priv_ok, space_ok, pass;

   assign priv_ok  = ~priv_cfg[1]  | (priv_cfg[0] ^ is_user);
   assign space_ok = ~space_cfg[1] | (space_cfg[0] == space_bit);
   assign pass     = priv_ok & space_ok;
   assign rd_ok    = pass & rd_en & ~is_write;
   assign wr_ok    = pass & wr_en &  is_write;

endmodule

// File: rtl/dacw_sticky.sv
module dacw_sticky #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] bits_q
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bits_q[i] <= 1'b0;
         else if (set_vec[i])
            bits_q[i] <= 1'b1;
         else if (clr_vec[i])
            bits_q[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/dac_watch_unit.sv
module dac_watch_unit
   import dacw_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_is_write,
   input  logic              acc_user,
   input  logic              acc_space,
   input  logic [1:0]        cfg_mode,
   input  logic [ADDR_W-1:0] cmp1_val,
   input  logic [ADDR_W-1:0] cmp2_val,
   input  logic [1:0]        cfg_priv1,
   input  logic [1:0]        cfg_priv2,
   input  logic [1:0]        cfg_space1,
   input  logic [1:0]        cfg_space2,
   input  logic              cfg_rden1,
   input  logic              cfg_wren1,
   input  logic              cfg_rden2,
   input  logic              cfg_wren2,
   input  logic              clr_strobe,
   input  logic [3:0]        clr_mask,
   output logic [3:0]        wp_status
);

   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_width
      $error("dac_watch_unit: ADDR_W must lie in 2..64");
   end
   if (EVT_W != 4) begin : g_bad_evt
      $error("dac_watch_unit: status width must be 4");
   end

   logic [NUM_CMP-1:0] hit, rd_ok, wr_ok;
   logic [1:0]         priv_sel  [NUM_CMP];
   logic [1:0]         space_sel [NUM_CMP];
   logic [NUM_CMP-1:0] rden_sel, wren_sel;
   logic [EVT_W-1:0]   set_vec, clr_vec;

   assign priv_sel[0]  = cfg_priv1;
   assign priv_sel[1]  = cfg_priv2;
   assign space_sel[0] = cfg_space1;
   assign space_sel[1] = cfg_space2;
   assign rden_sel     = {cfg_rden2, cfg_rden1};
   assign wren_sel     = {cfg_wren2, cfg_wren1};

   dacw_match #(.ADDR_W(ADDR_W)) u_match (
      .addr (acc_addr),
      .val1 (cmp1_val),
      .val2 (cmp2_val),
      .mode (cfg_mode),
      .hit  (hit)
   );

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      dacw_qual u_qual (
         .priv_cfg  (priv_sel[i]),
         .space_cfg (space_sel[i]),
         .rd_en     (rden_sel[i]),
         .wr_en     (wren_sel[i]),
         .is_user   (acc_user),
         .space_bit (acc_space),
         .is_write  (acc_is_write),
         .rd_ok     (rd_ok[i]),
         .wr_ok     (wr_ok[i])
      );
      assign set_vec[2*i]   = acc_valid & hit[i] & rd_ok[i];
      assign set_vec[2*i+1] = acc_valid & hit[i] & wr_ok[i];
   end

   assign clr_vec = clr_strobe ? clr_mask : '0;

   dacw_sticky #(.N(EVT_W)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .bits_q  (wp_status)
   );

endmodule

// File: rtl/dacw_checker.sv
module dacw_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_is_write,
   input logic              acc_user,
   input logic              acc_space,
   input logic [1:0]        cfg_mode,
   input logic [ADDR_W-1:0] cmp1_val,
   input logic [ADDR_W-1:0] cmp2_val,
   input logic [1:0]        cfg_priv1,
   input logic [1:0]        cfg_priv2,
   input logic [1:0]        cfg_space1,
   input logic [1:0]        cfg_space2,
   input logic              cfg_rden1,
   input logic              cfg_wren1,
   input logic              cfg_rden2,
   input logic              cfg_wren2,
   input logic              clr_strobe,
   input logic [3:0]        clr_mask,
   input logic [3:0]        wp_status
);

   logic plain1;
   assign plain1 = cfg_rden1 && (cfg_priv1 == 2'b00) && (cfg_space1 == 2'b00) && !acc_is_write;

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R1: assert (wp_status == 4'b0000);
      end
   end

   assert_exact_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && cfg_mode == 2'b00 && acc_addr == cmp1_val && plain1 |=> wp_status[0]);

   assert_inside_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && cfg_mode == 2'b10 && (acc_addr < cmp1_val || acc_addr >= cmp2_val)
      |=> (wp_status & ~$past(wp_status)) == 4'b0000);

   assert_read_only_rbits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !acc_is_write |=> ((wp_status & ~$past(wp_status)) & 4'b1010) == 4'b0000);

   assert_write_only_wbits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_is_write |=> ((wp_status & ~$past(wp_status)) & 4'b0101) == 4'b0000);

   assert_event_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && cfg_mode == 2'b11 && acc_addr < cmp1_val && plain1 && clr_strobe
      |=> wp_status[0]);

   assert_idle_no_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (wp_status & ~$past(wp_status)) == 4'b0000);

   for (genvar i = 0; i < 4; i++) begin : g_bit
      assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
         wp_status[i] && !(clr_strobe && clr_mask[i]) |=> wp_status[i]);
      assert_clear_works_R10: assert property (@(posedge clk) disable iff (!rst_n)
         clr_strobe && clr_mask[i] && !acc_valid |=> !wp_status[i]);
   end

endmodule

bind dac_watch_unit dacw_checker #(.ADDR_W(ADDR_W)) u_checker (.*);

// File: tb/tb_dac_watch_unit.sv
module tb_dac_watch_unit;

   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          acc_valid, acc_is_write, acc_user, acc_space;
   logic [AW-1:0] acc_addr, cmp1_val, cmp2_val;
   logic [1:0]    cfg_mode, cfg_priv1, cfg_priv2, cfg_space1, cfg_space2;
   logic          cfg_rden1, cfg_wren1, cfg_rden2, cfg_wren2;
   logic          clr_strobe;
   logic [3:0]    clr_mask;
   logic [3:0]    wp_status;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   dac_watch_unit #(.ADDR_W(AW)) dut (.*);

   task automatic check(input string tag, input logic [3:0] exp);
      checks++;
      if (wp_status !== exp) begin
         errors++;
         $display("FAIL %s status=%b expected=%b", tag, wp_status, exp);
      end
   endtask

   function automatic bit priv_pass(input logic [1:0] p, input logic u);
      if (p == 2'b10) return u;
      if (p == 2'b11) return !u;
      return 1'b1;
   endfunction

   function automatic bit space_pass(input logic [1:0] q, input logic s);
      if (q == 2'b10) return !s;
      if (q == 2'b11) return s;
      return 1'b1;
   endfunction

   function automatic logic [3:0] model(input logic [AW-1:0] a, input logic w,
                                        input logic u, input logic s);
      logic [3:0] r = 4'b0000;
      for (int i = 0; i < 2; i++) begin
         logic [AW-1:0] own = (i == 0) ? cmp1_val : cmp2_val;
         logic [1:0] p  = (i == 0) ? cfg_priv1 : cfg_priv2;
         logic [1:0] q  = (i == 0) ? cfg_space1 : cfg_space2;
         logic       re = (i == 0) ? cfg_rden1 : cfg_rden2;
         logic       we = (i == 0) ? cfg_wren1 : cfg_wren2;
         bit hit;
         case (cfg_mode)
            2'b00:   hit = (a == own);
            2'b01:   hit = ((a & cmp2_val) == (cmp1_val & cmp2_val));
            2'b10:   hit = (a >= cmp1_val) && (a < cmp2_val);
            default: hit = (a < cmp1_val) || (a >= cmp2_val);
         endcase
         if (hit && priv_pass(p, u) && space_pass(q, s) && (w ? we : re))
            r[2*i + (w ? 1 : 0)] = 1'b1;
      end
      return r;
   endfunction

   // starts and ends at a falling edge
   task automatic access(input logic [AW-1:0] a, input logic w, input logic u,
                         input logic s, input logic clr = 1'b0,
                         input logic [3:0] m = 4'b0000);
      acc_valid = 1'b1; acc_addr = a; acc_is_write = w; acc_user = u; acc_space = s;
      clr_strobe = clr; clr_mask = m;
      @(posedge clk);
      @(negedge clk);
      acc_valid = 1'b0; clr_strobe = 1'b0; clr_mask = 4'b0000;
   endtask

   task automatic clear(input logic [3:0] m);
      clr_strobe = 1'b1; clr_mask = m;
      @(posedge clk);
      @(negedge clk);
      clr_strobe = 1'b0; clr_mask = 4'b0000;
   endtask

   task automatic open_cfg();
      cfg_priv1 = 2'b00; cfg_priv2 = 2'b00; cfg_space1 = 2'b00; cfg_space2 = 2'b00;
      cfg_rden1 = 1'b1; cfg_wren1 = 1'b1; cfg_rden2 = 1'b1; cfg_wren2 = 1'b1;
   endtask

   task automatic sweep(input string tag, input logic [1:0] md,
                        input logic [AW-1:0] v1, input logic [AW-1:0] v2);
      cfg_mode = md; cmp1_val = v1; cmp2_val = v2;
      for (int a = 0; a < 256; a++) begin
         logic [3:0] e;
         e = model(AW'(a), a[0], a[1], a[2]);
         access(AW'(a), a[0], a[1], a[2]);
         check(tag, e);
         clear(4'hF);
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      acc_valid = 1'b0; acc_addr = '0; acc_is_write = 1'b0; acc_user = 1'b0; acc_space = 1'b0;
      cfg_mode = 2'b00; cmp1_val = '0; cmp2_val = '0;
      clr_strobe = 1'b0; clr_mask = 4'b0000;
      open_cfg();
      repeat (3) @(negedge clk);
      check("R1", 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);

      // R2..R5 full address sweeps
      sweep("R2", 2'b00, 8'h30, 8'hA5);
      sweep("R2", 2'b00, 8'h00, 8'hFF);
      sweep("R3", 2'b01, 8'h5A, 8'hF0);
      sweep("R4", 2'b10, 8'h30, 8'hA5);
      sweep("R4", 2'b10, 8'h00, 8'hFF);
      sweep("R5", 2'b11, 8'h30, 8'hA5);
      sweep("R5", 2'b11, 8'h01, 8'hFF);

      // R6 / R9: per-comparator enables with a shared hit
      cfg_mode = 2'b10; cmp1_val = 8'h30; cmp2_val = 8'hA5;
      for (int en = 0; en < 16; en++) begin
         for (int w = 0; w < 2; w++) begin
            logic [3:0] e;
            {cfg_wren2, cfg_rden2, cfg_wren1, cfg_rden1} = 4'(en);
            e = model(8'h50, w[0], 1'b0, 1'b0);
            access(8'h50, w[0], 1'b0, 1'b0);
            check(w ? "R9" : "R6", e);
            clear(4'hF);
         end
      end
      open_cfg();

      // R7 / R8: qualifier walk, exact mode, both comparators on the same value
      cfg_mode = 2'b00; cmp1_val = 8'h44; cmp2_val = 8'h44;
      for (int p = 0; p < 4; p++) begin
         for (int q = 0; q < 4; q++) begin
            for (int k = 0; k < 8; k++) begin
               logic [3:0] e;
               cfg_priv1 = 2'(p); cfg_priv2 = 2'(p + 1);
               cfg_space1 = 2'(q); cfg_space2 = 2'(q + 2);
               e = model(8'h44, k[0], k[1], k[2]);
               access(8'h44, k[0], k[1], k[2]);
               check(k[2] ? "R8" : "R7", e);
               clear(4'hF);
            end
         end
      end
      open_cfg();

      // R10: sticky bits and masked clear
      cfg_mode = 2'b10; cmp1_val = 8'h30; cmp2_val = 8'hA5;
      access(8'h40, 1'b0, 1'b0, 1'b0);
      access(8'h40, 1'b1, 1'b0, 1'b0);
      check("R10", 4'b1111);
      access(8'h10, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      check("R10", 4'b1111);
      clear(4'b0101);
      check("R10", 4'b1010);
      clear(4'b1000);
      check("R10", 4'b0010);
      clear(4'b1111);
      check("R10", 4'b0000);

      // R11: event wins over a simultaneous clear
      access(8'h40, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1111);
      check("R11", 4'b0101);
      access(8'h40, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0111);
      check("R11", 4'b1010);
      clear(4'hF);

      // R12: idle cycles and event timing
      acc_addr = 8'h40; acc_is_write = 1'b0; acc_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R12", 4'b0000);
      acc_valid = 1'b1;
      #2;
      check("R12", 4'b0000);
      @(posedge clk);
      @(negedge clk);
      acc_valid = 1'b0;
      check("R12", 4'b0101);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule